// File: doc/BRIEF.md
# Staged Memory Access Port

This block sits between a processing core and a word-addressed memory. It is the only way the core can reach that memory. No access goes straight from the request pins to the storage array. Every access passes through two staging registers: an address latch and a data latch. The storage array is a synchronous single-port word memory held inside the block.

A client raises `req` together with `wr`, `addr` and `wdata`, and holds all four steady until `done` pulses.

- **Load (read):** the address latch is filled first. A read command then goes to the array, and the word that comes back is captured into the data latch.
- **Store (write):** the data latch is filled first, then the address latch, and only then is the write command issued.

Both kinds of access take the same fixed number of cycles. A single-cycle `done` pulse closes each access. The data latch drives `rdata` at all times, so a word that was read stays visible until the next access starts loading the latch.

The address width is a parameter. Setting `ADDR_W` to 16 gives the full space of 65536 sixteen-bit words. The default is smaller so that elaboration stays light. Reset clears both latches and the sequencer, but it never alters the array contents.

Top module: `mem_staged_port`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W (16) bits, one per address. A word stored at an address is returned by a later load of that address.
- R2: A load runs in three ordered steps: the address latch is filled, then a read command is issued, then the array word is captured into the data latch. If `req` with `wr`=0 is seen high at idle on clock edge k, then `done` is high in the cycle that follows edge k+3, and `rdata` then equals the stored word.
- R3: A store runs in three ordered steps: the data latch is filled, then the address latch, then a write command. If `req` with `wr`=1 is seen at idle on edge k, then `done` is high in the cycle that follows edge k+3.
- R4: A request is accepted only when the block is idle. `busy` is high from the cycle after acceptance up to and including the `done` cycle. `done` is a one-cycle pulse.
- R5: `rdata` shows the data latch. It stays stable until the next access loads the latch. After a store, it shows the stored word.
- R6: Reset clears the address latch, the data latch and the sequencer, giving `rdata`=0, `busy`=0 and `done`=0. Reset leaves every array word unchanged.
- R7: While `req` is low, the block stays idle. It raises neither `busy` nor `done`.
- R8: A store changes only the addressed word. Other addresses keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, held until `done` |
| wr | input | 1 | 1 = store, 0 = load; held with `req` |
| addr | input | ADDR_W | Word address, held with `req` |
| wdata | input | DATA_W | Store data, held with `req` |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle pulse at the end of an access |
| rdata | output | DATA_W | Data latch contents |

## Verification
A sequencer stuck in a wrong state shows at the ports within one access: either `done` arrives in the wrong cycle, or `busy` does not match the four-cycle window.

A step taken out of order shows up in one of two ways:

- **Load steps out of order:** the data latch captures a word from a stale address. The mismatch appears on `rdata` in the `done` cycle.
- **Store steps out of order:** the wrong word is written, or the right word goes to the wrong address. This stays hidden until a later load of that address or of a neighbour, so the bench always reads back both.

A latch that loses its value between accesses is caught as soon as `rdata` moves while the block is idle.

// File: rtl/mport_pkg.sv
package mport_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LD_MDR = 3'd1,
    ST_LD_MAR = 3'd2,
    ST_RD_CMD = 3'd3,
    ST_RD_CAP = 3'd4,
    ST_WR_CMD = 3'd5,
    ST_DONE   = 3'd6
  } mport_state_e;

  // Next step of the access sequence.
  function automatic mport_state_e f_next(input mport_state_e cur,
                                           input logic req,
                                           input logic req_wr,
                                           input logic op_wr);
    mport_state_e nxt;
    case (cur)
      ST_IDLE:   nxt = req ? (req_wr ? ST_LD_MDR : ST_LD_MAR) : ST_IDLE;
      ST_LD_MDR: nxt = ST_LD_MAR;
      ST_LD_MAR: nxt = op_wr ? ST_WR_CMD : ST_RD_CMD;
      ST_RD_CMD: nxt = ST_RD_CAP;
      ST_RD_CAP: nxt = ST_DONE;
      ST_WR_CMD: nxt = ST_DONE;
      default:   nxt = ST_IDLE;
    endcase
    return nxt;
  endfunction

  function automatic logic f_busy(input mport_state_e cur);
    return cur != ST_IDLE;
  endfunction

endpackage

// File: rtl/mport_seq.sv
module mport_seq
  import mport_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic wr,
  output logic op_wr,
  output logic mar_ld,
  output logic mdr_ld_wr,
  output logic mdr_ld_rd,
  output logic mem_re,
  output logic mem_we,
  output logic busy,
  output logic done
);

  mport_state_e state_q, state_d;
  logic         accept;

  assign accept  = (state_q == ST_IDLE) && req;
  assign state_d = f_next(state_q, req, wr, op_wr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_wr   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) op_wr <= wr;
    end
  end

  assign mdr_ld_wr = (state_q == ST_LD_MDR);
  assign mar_ld    = (state_q == ST_LD_MAR);
  assign mem_re    = (state_q == ST_RD_CMD);
  assign mdr_ld_rd = (state_q == ST_RD_CAP);
  assign mem_we    = (state_q == ST_WR_CMD);
  assign done      = (state_q == ST_DONE);
  assign busy      = f_busy(state_q);

  // R2: the read command follows the address latch load
  a_r2_read_after_mar: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> $past(mar_ld));
  // R2: the data latch captures the array word right after the read command
  a_r2_capture_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mdr_ld_rd |-> $past(mem_re));
  // R3: the write command follows the address latch load
  a_r3_write_after_mar: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mar_ld));
  // R3: for a store, the address latch is loaded after the data latch
  a_r3_mar_after_mdr: assert property (@(posedge clk) disable iff (!rst_n)
    (mar_ld && op_wr) |-> $past(mdr_ld_wr));
  // R4: done is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4: an accepted request makes the block busy on the next cycle
  a_r4_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R7: with no request at idle, the block stays idle
  a_r7_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req) |=> !busy);
  // R4: at most one step strobe is active per cycle
  a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mar_ld, mdr_ld_wr, mdr_ld_rd, mem_re, mem_we, done}));

endmodule

// File: rtl/mport_stage.sv
module mport_stage #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mar_ld,
  input  logic              mdr_ld_wr,
  input  logic              mdr_ld_rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] mem_word,
  output logic [ADDR_W-1:0] mar_q,
  output logic [DATA_W-1:0] mdr_q
);

  logic mdr_load;
  assign mdr_load = mdr_ld_wr || mdr_ld_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mar_q <= '0;
      mdr_q <= '0;
    end else begin
      if (mar_ld)         mar_q <= addr;
      if (mdr_ld_wr)      mdr_q <= wdata;
      else if (mdr_ld_rd) mdr_q <= mem_word;
    end
  end

  // R5: the data latch holds its value unless a load step is active
  a_r5_mdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mdr_load |=> $stable(mdr_q));
  // R2: the address latch changes only on its load step
  a_r2_mar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mar_ld |=> $stable(mar_q));

endmodule

// File: rtl/mport_array.sv
module mport_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              re,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store_q [DEPTH];

  // No reset on the storage: R6 keeps contents across reset.
  always_ff @(posedge clk) begin
    if (we) store_q[addr] <= din;
    if (re) dout <= store_q[addr];
  end

  // R1: read and write commands never meet on the single port
  a_r1_single_cmd: assert property (@(posedge clk) !(re && we));

endmodule

// File: rtl/mem_staged_port.sv
module mem_staged_port #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);

  logic              op_wr;
  logic              mar_ld;
  logic              mdr_ld_wr;
  logic              mdr_ld_rd;
  logic              mem_re;
  logic              mem_we;
  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] mdr_q;
  logic [DATA_W-1:0] mem_word;

  mport_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .wr        (wr),
    .op_wr     (op_wr),
    .mar_ld    (mar_ld),
    .mdr_ld_wr (mdr_ld_wr),
    .mdr_ld_rd (mdr_ld_rd),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .busy      (busy),
    .done      (done)
  );

  mport_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .mar_ld    (mar_ld),
    .mdr_ld_wr (mdr_ld_wr),
    .mdr_ld_rd (mdr_ld_rd),
    .addr      (addr),
    .wdata     (wdata),
    .mem_word  (mem_word),
    .mar_q     (mar_q),
    .mdr_q     (mdr_q)
  );

  mport_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk  (clk),
    .re   (mem_re),
    .we   (mem_we),
    .addr (mar_q),
    .din  (mdr_q),
    .dout (mem_word)
  );

  assign rdata = mdr_q;

  // R5: while idle, rdata does not move
  a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req) |=> $stable(rdata));

endmodule

// File: tb/tb_mem_staged_port.sv
`timescale 1ns/1ps
module tb_mem_staged_port;

  localparam int AW    = 10;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          busy, done;
  logic [DW-1:0] rdata;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  mem_staged_port #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
    .wdata(wdata), .busy(busy), .done(done), .rdata(rdata)
  );

  // Behavioural reference: cycle count since acceptance, plus a word list.
  int            m_cnt = 0;
  bit            m_wr = 0;
  int            m_addr = 0;
  logic [DW-1:0] m_data = '0;
  logic [DW-1:0] m_rdata = '0;
  logic [DW-1:0] m_mem [DEPTH];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0;
      m_rdata = '0;
    end else if (m_cnt == 0) begin
      if (req) begin
        m_cnt = 1; m_wr = wr; m_addr = int'(addr); m_data = wdata;
      end
    end else begin
      if (m_cnt == 1 && m_wr) m_rdata = m_data;
      if (m_cnt == 3 && m_wr) m_mem[m_addr] = m_data;
      if (m_cnt == 3 && !m_wr) m_rdata = m_mem[m_addr];
      m_cnt = (m_cnt == 4) ? 0 : m_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R4 busy", 32'(busy), 32'(m_cnt != 0));
      check("R4 done", 32'(done), 32'(m_cnt == 4));
      check("R5 rdata", 32'(rdata), 32'(m_rdata));
    end
  end

  task automatic access(input bit w, input int a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int lat);
    @(negedge clk);
    req = 1'b1; wr = w; addr = AW'(a); wdata = d;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!done && lat < 20);
    rd = rdata;
    req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    int lat;
    repeat (3) @(negedge clk);
    // R6: reset state
    check("R6 rdata after reset", 32'(rdata), 32'h0);
    check("R6 busy after reset", 32'(busy), 32'h0);
    check("R6 done after reset", 32'(done), 32'h0);
    rst_n = 1'b1;

    // R7: idle with no request
    repeat (5) @(negedge clk);
    check("R7 idle busy", 32'(busy), 32'h0);

    // R3: store latency and rdata shows stored word
    access(1'b1, 5, 16'hA5C3, rd, lat);
    check("R3 store latency", 32'(lat), 32'd4);
    check("R5 rdata after store", 32'(rd), 32'hA5C3);
    access(1'b1, 6, 16'h1234, rd, lat);
    access(1'b1, 0, 16'hFFFF, rd, lat);
    access(1'b1, DEPTH - 1, 16'h8001, rd, lat);

    // R2/R1: load latency and data
    access(1'b0, 5, 16'h0, rd, lat);
    check("R2 load latency", 32'(lat), 32'd4);
    check("R1 load addr5", 32'(rd), 32'hA5C3);
    access(1'b0, DEPTH - 1, 16'h0, rd, lat);
    check("R1 load top addr", 32'(rd), 32'h8001);
    access(1'b0, 0, 16'h0, rd, lat);
    check("R1 load addr0", 32'(rd), 32'hFFFF);

    // R8: overwrite 5, neighbour 6 untouched
    access(1'b1, 5, 16'h0F0F, rd, lat);
    access(1'b0, 6, 16'h0, rd, lat);
    check("R8 neighbour kept", 32'(rd), 32'h1234);
    access(1'b0, 5, 16'h0, rd, lat);
    check("R8 overwrite", 32'(rd), 32'h0F0F);

    // R5: rdata holds while idle
    repeat (6) @(negedge clk);
    check("R5 hold idle", 32'(rdata), 32'h0F0F);

    // R6: reset clears latches, keeps array
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 rdata cleared", 32'(rdata), 32'h0);
    rst_n = 1'b1;
    access(1'b0, 6, 16'h0, rd, lat);
    check("R6 array kept", 32'(rd), 32'h1234);

    // back-to-back accesses with differing patterns
    for (int i = 0; i < 8; i++) begin
      access(1'b1, 100 + i, DW'(16'h3C00 + i * 16'h0111), rd, lat);
    end
    for (int i = 7; i >= 0; i--) begin
      access(1'b0, 100 + i, 16'h0, rd, lat);
      check("R1 pattern readback", 32'(rd), 32'(DW'(16'h3C00 + i * 16'h0111)));
    end

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule